// File: doc/BRIEF.md
# Run/Stop Switch Fault-Clear Sequencer

This block turns a debounced run/stop switch level and a fault severity code into the controller's operating mode. With no fault or only a non-fatal one, moving the switch to Run starts run mode straight away and leaves the fault record as it is. With a fatal fault present, the same move keeps the controller stopped and opens a timed recovery window instead. During that window the operator can clear the faults and start running with a deliberate Run, Stop, Run toggle. Each of the first two positions must be held for a minimum time.

Time is measured in ticks from a one-cycle millisecond strobe. The window length and the minimum hold are parameters, defaulting to 5000 and 500 ticks. A window-active flag tells the LED driver to blink the run indicator. The fault-clear output is a single-cycle request to whatever holds the fault tables. An enable input lets configuration take the switch out of mode selection. Debouncing and fault storage are done elsewhere.

Top module: `runstop_fault_seq`

## Requirements
- R1: After reset `runMode`, `faultClear` and `windowActive` are all 0. A switch already at Run when reset ends does not count as a move to Run.
- R2: With `swEnable` high and `faultLevel` equal to 2'b00 (none) or 2'b01 (non-fatal), a Stop-to-Run move sets `runMode` to 1 one clock later. No `faultClear` pulse follows and no window opens.
- R3: A Run-to-Stop move with `swEnable` high clears `runMode` one clock later. Outside a window, a fatal code (`faultLevel` 2'b10 or 2'b11) forces `runMode` to 0 one clock later.
- R4: With `swEnable` high and a fatal code present, a Stop-to-Run move sets `windowActive` one clock later. `runMode` stays 0 throughout the window.
- R5: Inside a window, the clear sequence is three steps. The switch stays at Run for at least HOLD_MS ticks, then stays at Stop for at least HOLD_MS ticks, then returns to Run. On the clock after that return, `faultClear` is 1, `runMode` is 1 and `windowActive` is 0.
- R6: A window that is not completed closes after exactly WINDOW_MS ticks from its opening. On closing, `runMode` stays 0 and no `faultClear` pulse is given.
- R7: A Run or Stop hold shorter than HOLD_MS ticks inside a window restarts the toggle sequence and gives no `faultClear`. It does not restart the window timer.
- R8: After a window closes, a later Stop-to-Run move with a fatal code present opens a fresh window, which can itself be completed.
- R9: While `swEnable` is low, switch moves change neither `runMode` nor open a window, and an open window closes with no `faultClear`. Moves made while disabled are not replayed when the switch is enabled again.
- R10: `faultClear` is high for exactly one clock per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle strobe once per millisecond |
| swEnable | input | 1 | 1: switch selects the mode; 0: switch is ignored |
| swRun | input | 1 | Debounced switch level, 1 = Run, 0 = Stop |
| faultLevel | input | 2 | 00 none, 01 non-fatal, 1x fatal |
| runMode | output | 1 | 1 while the controller is in run mode |
| faultClear | output | 1 | One-clock request to clear the fault tables |
| windowActive | output | 1 | High while a recovery window is open (LED blink) |

## Verification
The assertions assume that `msTick` is a single-cycle strobe and that `swRun` is already debounced. This means a switch move is one clean level change rather than a burst. They also assume that the fault source drops the fatal code soon after `faultClear`. The bench generates the tick from a divider that is high for one clock in every four. It moves the switch only at isolated points separated by several clocks. It lowers `faultLevel` on the clock edge right after each observed clear pulse, which models the fault table being emptied.

// File: rtl/rss_pkg.sv
package rss_pkg;

  // Position of the recovery sequence inside a window
  typedef enum logic [1:0] {
    STEP_IDLE      = 2'd0,
    STEP_RUN_HOLD  = 2'd1,
    STEP_STOP_HOLD = 2'd2,
    STEP_REARM     = 2'd3
  } stepT;

  // Strobes from the control FSM to the tick counters
  typedef struct packed {
    logic winOpen;   // restart the window counter
    logic winRun;    // window counter advances on ticks
    logic holdClr;   // restart the hold counter
  } timerCmdT;

  localparam logic [1:0] FAULT_FATAL_MIN = 2'b10;

endpackage

// File: rtl/rss_timers.sv
module rss_timers
  import rss_pkg::*;
#(
  parameter int WINDOW_MS = 5000,
  parameter int HOLD_MS   = 500
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     msTick,
  input  timerCmdT cmd,
  output logic     winExpire,
  output logic     holdMet
);

  localparam int WIN_W  = $clog2(WINDOW_MS + 1);
  localparam int HOLD_W = $clog2(HOLD_MS + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WINDOW_MS - 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_MS);

  logic [WIN_W-1:0]  windowCnt;
  logic [HOLD_W-1:0] holdCnt;

  // Window counter: ticks since the window opened
  always_ff @(posedge clk) begin
    if (!rstN || cmd.winOpen) begin
      windowCnt <= '0;
    end else if (cmd.winRun && msTick) begin
      windowCnt <= (windowCnt == WIN_LAST) ? '0 : windowCnt + 1'b1;
    end
  end

  assign winExpire = cmd.winRun && msTick && (windowCnt == WIN_LAST);

  // Hold counter: saturating tick count since the last step entry
  always_ff @(posedge clk) begin
    if (!rstN || cmd.holdClr) begin
      holdCnt <= '0;
    end else if (msTick && (holdCnt < HOLD_MAX)) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdMet = (holdCnt >= HOLD_MAX);

  AST_WINDOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    windowCnt <= WIN_LAST);  // R6

  AST_HOLD_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= HOLD_MAX);  // R7

  AST_OPEN_RESTARTS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    cmd.winOpen |=> (windowCnt == '0));  // R8

endmodule

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     swEnable,
  input  logic     swRun,
  input  logic     faultFatal,
  input  logic     winExpire,
  input  logic     holdMet,
  output timerCmdT cmd,
  output logic     runMode,
  output logic     faultClear,
  output logic     windowActive
);

  stepT step, stepNext;
  logic prevSw;
  logic runNext, clearNext, complete;
  logic runEdge, stopEdge;

  // Reset to Run so a switch already at Run is not taken as a move
  always_ff @(posedge clk) begin
    if (!rstN) prevSw <= 1'b1;
    else       prevSw <= swRun;
  end

  assign runEdge  = swEnable &&  swRun && !prevSw;
  assign stopEdge = swEnable && !swRun &&  prevSw;

  always_comb begin
    stepNext    = step;
    runNext     = runMode;
    clearNext   = 1'b0;
    complete    = 1'b0;
    cmd         = '0;
    cmd.winRun  = (step != STEP_IDLE);
    case (step)
      STEP_IDLE: begin
        if (faultFatal) runNext = 1'b0;
        if (runEdge) begin
          if (faultFatal) begin
            stepNext    = STEP_RUN_HOLD;
            cmd.winOpen = 1'b1;
            cmd.holdClr = 1'b1;
          end else begin
            runNext = 1'b1;
          end
        end else if (stopEdge) begin
          runNext = 1'b0;
        end
      end
      STEP_RUN_HOLD: begin
        runNext = 1'b0;
        if (stopEdge) begin
          cmd.holdClr = 1'b1;
          stepNext    = holdMet ? STEP_STOP_HOLD : STEP_REARM;
        end
      end
      STEP_STOP_HOLD: begin
        runNext = 1'b0;
        if (runEdge) begin
          if (holdMet) begin
            complete = 1'b1;
          end else begin
            cmd.holdClr = 1'b1;
            stepNext    = STEP_RUN_HOLD;
          end
        end
      end
      default: begin
        runNext = 1'b0;
        if (runEdge) begin
          cmd.holdClr = 1'b1;
          stepNext    = STEP_RUN_HOLD;
        end
      end
    endcase
    if (step != STEP_IDLE) begin
      if (complete) begin
        stepNext  = STEP_IDLE;
        runNext   = 1'b1;
        clearNext = 1'b1;
      end else if (winExpire || !swEnable) begin
        stepNext = STEP_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step       <= STEP_IDLE;
      runMode    <= 1'b0;
      faultClear <= 1'b0;
    end else begin
      step       <= stepNext;
      runMode    <= runNext;
      faultClear <= clearNext;
    end
  end

  assign windowActive = (step != STEP_IDLE);

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    faultClear |=> !faultClear);  // R10

  AST_CLEAR_STARTS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    faultClear |-> (runMode && !windowActive));  // R5

  AST_WINDOW_HOLDS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    windowActive |-> !runMode);  // R4

  AST_WINDOW_NEEDS_FATAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(windowActive) |-> $past(faultFatal));  // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !swEnable |=> (!windowActive && !faultClear));  // R9

  AST_EXPIRY_NO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (windowActive && winExpire && !runEdge) |=> (!runMode && !faultClear));  // R6

endmodule

// File: rtl/runstop_fault_seq.sv
module runstop_fault_seq
  import rss_pkg::*;
#(
  parameter int WINDOW_MS = 5000,
  parameter int HOLD_MS   = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       swEnable,
  input  logic       swRun,
  input  logic [1:0] faultLevel,
  output logic       runMode,
  output logic       faultClear,
  output logic       windowActive
);

  timerCmdT timerCmd;
  logic     winExpire;
  logic     holdMet;
  logic     faultFatal;

  assign faultFatal = (faultLevel >= FAULT_FATAL_MIN);

  rss_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .swEnable     (swEnable),
    .swRun        (swRun),
    .faultFatal   (faultFatal),
    .winExpire    (winExpire),
    .holdMet      (holdMet),
    .cmd          (timerCmd),
    .runMode      (runMode),
    .faultClear   (faultClear),
    .windowActive (windowActive)
  );

  rss_timers #(
    .WINDOW_MS (WINDOW_MS),
    .HOLD_MS   (HOLD_MS)
  ) u_timers (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .cmd       (timerCmd),
    .winExpire (winExpire),
    .holdMet   (holdMet)
  );

endmodule

// File: tb/sim_runstop_fault_seq.sv
`timescale 1ns/1ps
module sim_runstop_fault_seq;

  localparam int WIN  = 40;
  localparam int HOLD = 5;
  localparam int DIV  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       swEnable = 1'b1;
  logic       swRun = 1'b0;
  logic [1:0] faultLevel = 2'b00;
  logic       runMode, faultClear, windowActive;

  runstop_fault_seq #(.WINDOW_MS(WIN), .HOLD_MS(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .swEnable(swEnable),
    .swRun(swRun), .faultLevel(faultLevel), .runMode(runMode),
    .faultClear(faultClear), .windowActive(windowActive)
  );

  always #5 clk = ~clk;

  int divCnt = 0;
  always @(negedge clk) begin
    if (divCnt == DIV - 1) begin divCnt <= 0; msTick <= 1'b1; end
    else begin divCnt <= divCnt + 1; msTick <= 1'b0; end
  end

  int cyc = 0;
  int winTicks = 0;
  int clearCount = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (windowActive && msTick) winTicks <= winTicks + 1;
    if (faultClear) clearCount <= clearCount + 1;
  end

  int checks = 0;
  int failures = 0;

  task automatic check(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  typedef struct {
    int    due;
    string tag;
    logic  run;
    logic  win;
    logic  clr;
  } expT;
  expT q[$];

  task automatic expectAt(string tag, int off, logic r, logic w, logic c);
    expT e;
    e.due = cyc + off; e.tag = tag; e.run = r; e.win = w; e.clr = c;
    q.push_back(e);
  endtask

  // Monitor: compare scoreboard items when their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      expT e;
      e = q.pop_front();
      check(e.tag, "runMode", int'(runMode), int'(e.run));
      check(e.tag, "windowActive", int'(windowActive), int'(e.win));
      check(e.tag, "faultClear", int'(faultClear), int'(e.clr));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int base;
    int tickBase;
    step(4);
    // R1: reset state, switch at Stop
    rstN = 1'b1;
    expectAt("R1", 1, 0, 0, 0); step(3);

    // R2: non-fatal fault, move to Run
    faultLevel = 2'b01; swRun = 1'b1;
    expectAt("R2", 1, 1, 0, 0); step(3);
    // R3: move to Stop
    swRun = 1'b0;
    expectAt("R3", 1, 0, 0, 0); step(3);
    // R2: no fault, move to Run
    faultLevel = 2'b00; swRun = 1'b1;
    expectAt("R2", 1, 1, 0, 0); step(3);
    // R3: fatal fault forces stop
    faultLevel = 2'b10;
    expectAt("R3", 1, 0, 0, 0); step(3);
    swRun = 1'b0; step(3);

    // R4: fatal + Run opens window
    swRun = 1'b1;
    expectAt("R4", 1, 0, 1, 0); step(8 * DIV);
    swRun = 1'b0;
    expectAt("R5", 1, 0, 1, 0); step(8 * DIV);
    base = clearCount;
    swRun = 1'b1;
    expectAt("R5", 1, 1, 0, 1);
    expectAt("R10", 2, 1, 0, 0);
    step(1); faultLevel = 2'b00; step(3);
    check("R10", "clear pulses", clearCount - base, 1);

    // R9: disabled switch ignored
    swEnable = 1'b0; swRun = 1'b0;
    expectAt("R9", 1, 1, 0, 0); step(3);
    swEnable = 1'b1;
    expectAt("R9", 1, 1, 0, 0); step(3);
    swRun = 1'b1; step(3);
    swRun = 1'b0;
    expectAt("R3", 1, 0, 0, 0); step(3);
    faultLevel = 2'b11; swEnable = 1'b0; swRun = 1'b1;
    expectAt("R9", 1, 0, 0, 0); step(3);
    swEnable = 1'b1; swRun = 1'b0; step(3);

    // R7 and R6: short holds restart, window expires on schedule
    tickBase = winTicks;
    swRun = 1'b1;
    expectAt("R4", 1, 0, 1, 0); step(2 * DIV);
    swRun = 1'b0; step(8 * DIV);
    swRun = 1'b1; step(8 * DIV);
    swRun = 1'b0; step(2 * DIV);
    swRun = 1'b1;
    expectAt("R7", 1, 0, 1, 0); step(2);
    for (int i = 0; i < 400 && windowActive; i++) @(negedge clk);
    check("R6", "window ticks", winTicks - tickBase, WIN);
    check("R6", "runMode after expiry", int'(runMode), 0);
    check("R7", "clear pulses", clearCount - base, 1);
    step(3);

    // R8: a later move to Run opens a new window that completes
    swRun = 1'b0; step(4);
    swRun = 1'b1;
    expectAt("R8", 1, 0, 1, 0); step(8 * DIV);
    swRun = 1'b0; step(8 * DIV);
    swRun = 1'b1;
    expectAt("R8", 1, 1, 0, 1);
    step(1); faultLevel = 2'b00; step(4);
    check("R8", "clear pulses", clearCount - base, 2);
    check("R8", "runMode", int'(runMode), 1);
    step(3);
    finishRun();
  end

endmodule